// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block drives one DMA channel through a linked list of six-word transfer descriptors held in local memory. Software sets the channel enable and the chain enable, then writes a chain pointer. The block reads the descriptor that the pointer names through a single memory-request port and loads the channel's internal index, internal modifier, word count, external index and external modifier. It then moves the words and follows the next-descriptor pointer stored in the descriptor.

Each chain pointer carries two flag bits above the address. The flags apply to the descriptor that the pointer names. One flag selects the direction. In the outbound direction the block reads internal memory and presents each word with its external address. In the inbound direction it writes the word that the external side supplies for the current external address. The other flag requests a one-cycle completion pulse once that descriptor's words are done. When a next pointer has a zero address field, the chain ends. Dropping the channel enable abandons whatever is in progress.

Top module: `dma_chain_loader`

## Requirements
- R1: A descriptor fetch starts only when the block is idle, the pointer-write strobe is high, the channel enable and the chain enable are both high, and the address field of the written pointer is non-zero. In every other case the block stays idle and issues no memory request.
- R2: The pointer names the highest word of a descriptor. The six fetch reads go to the pointer address minus 0, 1, 2, 3, 4 and 5, in that order. They load the internal index, internal modifier, word count, external index, external modifier and next pointer respectively. A read counts only when it is accepted (request and acknowledge both high).
- R3: Pointer layout: the address is in bits [18:0], bit 19 requests the completion pulse and bit 20 selects the direction. The flags of a pointer govern the descriptor that the pointer addresses.
- R4: With direction 1, each transfer word is a read (write-enable low) of internal memory at the internal index. In the cycle that read is accepted, the output-valid strobe is high and carries the read data, and the external-address output shows the current external index.
- R5: With direction 0, each transfer word is a write of the inbound data input to internal memory at the internal index. The output-valid strobe stays low.
- R6: After each accepted transfer word, the internal index advances by the internal modifier and the external index advances by the external modifier, both modulo 2^19. The count drops by one. A descriptor with count zero moves no words.
- R7: After a descriptor's last word, and before the next fetch, the completion output pulses for exactly one cycle if bit 19 of that descriptor's pointer was set. Otherwise it stays low.
- R8: After a descriptor completes, a next pointer with a non-zero address field starts the fetch of that descriptor. A zero address field returns the block to idle.
- R9: Busy is low out of reset. It is high from the cycle after a valid start until the chain ends.
- R10: When the channel enable goes low, the memory request drops at once and the block is idle on the next cycle. The rest of the chain is abandoned and does not resume when the enable returns.
- R11: While a memory request is not acknowledged, its address and write-enable hold steady until it is accepted or withdrawn.
- R12: A pointer write while busy has no effect on the access stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Channel enable |
| ctl_chain | input | 1 | Chain enable |
| ptr_wr | input | 1 | Chain pointer write strobe |
| ptr_wdata | input | 21 | Chain pointer value (address plus two flags) |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 19 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid when accepted |
| xfer_ext_addr | output | 19 | Current external index |
| xfer_in_data | input | 32 | Inbound word for the current external index |
| xfer_out_valid | output | 1 | Outbound word valid |
| xfer_out_data | output | 32 | Outbound word |

## Verification
The hardest case to reach is an abort that lands in the middle of a descriptor's words while the memory is stalling. The partly advanced indices must be dropped, and no request may leak out when the enable returns. The bench gets there by counting accepted accesses in its reference stream and pulling the enable low after a fixed number of them, under a pseudo-random acknowledge pattern. A second hard case is a chain that mixes both directions, a negative modifier, a zero-count descriptor and a pulse flag that differs per link. A pointer write injected while the chain is running must leave the access stream unchanged.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_DONE  = 3'd3,
    ST_NEXT  = 3'd4
  } dmac_state_e;

  localparam int unsigned SLOT_W = 3;
  // fetch slot k reads (pointer - k)
  localparam logic [SLOT_W-1:0] SLOT_II  = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_IM  = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_CNT = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_EI  = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_EM  = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_CP  = 3'd5;
endpackage

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic                start_req,
  input  logic                fetch_ack,
  input  logic                cnt_zero,
  input  logic                next_valid,
  output dmac_state_e         state,
  output logic [SLOT_W-1:0]   slot
);
  dmac_state_e         state_q, state_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic                slot_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_req) state_d = ST_FETCH;
      ST_FETCH: if (fetch_ack && (slot_q == SLOT_CP)) state_d = ST_XFER;
      ST_XFER:  if (cnt_zero) state_d = ST_DONE;
      ST_DONE:  state_d = ST_NEXT;
      ST_NEXT:  state_d = next_valid ? ST_FETCH : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (!ctl_en) state_d = ST_IDLE;
  end

  always_comb begin
    slot_en = 1'b0;
    slot_d  = slot_q;
    if (state_q != ST_FETCH) begin
      slot_en = (slot_q != '0);
      slot_d  = '0;
    end else if (fetch_ack) begin
      slot_en = 1'b1;
      slot_d  = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      if (slot_en) slot_q <= slot_d;
    end
  end

  assign state = state_q;
  assign slot  = slot_q;
endmodule

// File: rtl/dmac_tcb_regs.sv
module dmac_tcb_regs
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [DATA_W-1:0]   word,
  input  logic                step,
  output logic [ADDR_W-1:0]   ii,
  output logic [ADDR_W-1:0]   ei,
  output logic                cnt_zero,
  output logic [ADDR_W+1:0]   cp_next
);
  logic [ADDR_W-1:0] ii_q, ii_d, im_q, im_d, ei_q, ei_d, em_q, em_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W+1:0] cp_q, cp_d;
  logic              reg_en;

  always_comb begin
    ii_d  = ii_q;
    im_d  = im_q;
    ei_d  = ei_q;
    em_d  = em_q;
    cnt_d = cnt_q;
    cp_d  = cp_q;
    if (load_en) begin
      unique case (slot)
        SLOT_II:  ii_d  = word[ADDR_W-1:0];
        SLOT_IM:  im_d  = word[ADDR_W-1:0];
        SLOT_CNT: cnt_d = word[CNT_W-1:0];
        SLOT_EI:  ei_d  = word[ADDR_W-1:0];
        SLOT_EM:  em_d  = word[ADDR_W-1:0];
        SLOT_CP:  cp_d  = word[ADDR_W+1:0];
        default:  ;
      endcase
    end else if (step) begin
      ii_d  = ii_q + im_q;
      ei_d  = ei_q + em_q;
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign reg_en = load_en | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ii_q  <= '0;
      im_q  <= '0;
      ei_q  <= '0;
      em_q  <= '0;
      cnt_q <= '0;
      cp_q  <= '0;
    end else if (reg_en) begin
      ii_q  <= ii_d;
      im_q  <= im_d;
      ei_q  <= ei_d;
      em_q  <= em_d;
      cnt_q <= cnt_d;
      cp_q  <= cp_d;
    end
  end

  assign ii       = ii_q;
  assign ei       = ei_q;
  assign cnt_zero = (cnt_q == '0);
  assign cp_next  = cp_q;
endmodule

// File: rtl/dma_chain_loader.sv
module dma_chain_loader
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic                ctl_chain,
  input  logic                ptr_wr,
  input  logic [ADDR_W+1:0]   ptr_wdata,
  output logic                busy,
  output logic                irq,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   xfer_ext_addr,
  input  logic [DATA_W-1:0]   xfer_in_data,
  output logic                xfer_out_valid,
  output logic [DATA_W-1:0]   xfer_out_data
);
  localparam int unsigned PTR_W   = ADDR_W + 2;
  localparam int unsigned IRQ_BIT = ADDR_W;
  localparam int unsigned DIR_BIT = ADDR_W + 1;

  dmac_state_e         state;
  logic [SLOT_W-1:0]   slot;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                ptr_en;
  logic                start_req, fetch_ack, step, cnt_zero, next_valid;
  logic                in_fetch, in_xfer;
  logic [ADDR_W-1:0]   ii, ei, fetch_addr;
  logic [PTR_W-1:0]    cp_next;

  assign in_fetch   = (state == ST_FETCH);
  assign in_xfer    = (state == ST_XFER);
  assign start_req  = ctl_en & ctl_chain & ptr_wr & (ptr_wdata[ADDR_W-1:0] != '0);
  assign next_valid = (cp_next[ADDR_W-1:0] != '0);

  assign mem_req   = ctl_en & (in_fetch | (in_xfer & ~cnt_zero));
  assign fetch_ack = mem_req & mem_ack & in_fetch;
  assign step      = mem_req & mem_ack & in_xfer;

  assign fetch_addr = ptr_q[ADDR_W-1:0] - {{(ADDR_W-SLOT_W){1'b0}}, slot};
  assign mem_addr   = in_fetch ? fetch_addr : ii;
  assign mem_we     = in_xfer & ~ptr_q[DIR_BIT];
  assign mem_wdata  = xfer_in_data;

  assign xfer_ext_addr  = ei;
  assign xfer_out_valid = step & ptr_q[DIR_BIT];
  assign xfer_out_data  = mem_rdata;

  assign irq  = (state == ST_DONE) & ptr_q[IRQ_BIT];
  assign busy = (state != ST_IDLE);

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if ((state == ST_IDLE) && start_req) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_wdata;
    end else if (state == ST_NEXT) begin
      ptr_en = 1'b1;
      ptr_d  = cp_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  dmac_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .start_req  (start_req),
    .fetch_ack  (fetch_ack),
    .cnt_zero   (cnt_zero),
    .next_valid (next_valid),
    .state      (state),
    .slot       (slot)
  );

  dmac_tcb_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (fetch_ack),
    .slot     (slot),
    .word     (mem_rdata),
    .step     (step),
    .ii       (ii),
    .ei       (ei),
    .cnt_zero (cnt_zero),
    .cp_next  (cp_next)
  );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int unsigned ADDR_W = 19
)(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_en,
  input logic              ctl_chain,
  input logic              ptr_wr,
  input logic [ADDR_W+1:0] ptr_wdata,
  input logic              busy,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              xfer_out_valid
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ptr_wr && ctl_en && ctl_chain && (ptr_wdata[ADDR_W-1:0] != '0)));

  assert_out_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_out_valid |-> (mem_req && mem_ack && !mem_we));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_pulse_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (busy && !mem_req));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !busy);

  assert_abort_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !mem_req);

  assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));
endmodule

bind dma_chain_loader dmac_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctl_en         (ctl_en),
  .ctl_chain      (ctl_chain),
  .ptr_wr         (ptr_wr),
  .ptr_wdata      (ptr_wdata),
  .busy           (busy),
  .irq            (irq),
  .mem_req        (mem_req),
  .mem_ack        (mem_ack),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .xfer_out_valid (xfer_out_valid)
);

// File: tb/test_dma_chain_loader.sv
`timescale 1ns/1ps
module test_dma_chain_loader;
  localparam int AW = 19;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int PW = AW + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_en, ctl_chain, ptr_wr;
  logic [PW-1:0] ptr_wdata;
  logic busy, irq, mem_req, mem_we, mem_ack, xfer_out_valid;
  logic [AW-1:0] mem_addr, xfer_ext_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, xfer_in_data, xfer_out_data;

  always #2 clk = ~clk;

  dma_chain_loader #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_chain_loader (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_chain(ctl_chain),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_ext_addr(xfer_ext_addr),
    .xfer_in_data(xfer_in_data), .xfer_out_valid(xfer_out_valid), .xfer_out_data(xfer_out_data)
  );

  // memory and external-side models
  logic [DW-1:0] mem [0:255];
  logic [7:0]    lf;
  logic          stall_mode;

  assign mem_rdata    = mem[mem_addr[7:0]];
  assign mem_ack      = !stall_mode || lf[0] || lf[3];
  assign xfer_in_data = 32'hA500_0000 ^ {13'h0, xfer_ext_addr};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf <= 8'h5A;
    else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  // reference event stream
  typedef struct {
    int            kind;   // 0 memory access, 1 completion pulse
    logic [AW-1:0] addr;
    logic          we;
    logic [DW-1:0] data;
    logic          outv;
    logic [AW-1:0] ext;
    string         req;
  } ev_t;

  ev_t q[$];
  ev_t e;
  int  total = 0;
  int  bad   = 0;
  int  consumed = 0;
  bit  chk_on = 0;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic ev_t mk(int kind, logic [AW-1:0] a, logic we, logic [DW-1:0] d,
                             logic outv, logic [AW-1:0] x, string r);
    ev_t t;
    t.kind = kind; t.addr = a; t.we = we; t.data = d; t.outv = outv; t.ext = x; t.req = r;
    return t;
  endfunction

  task automatic build_expect(input logic [PW-1:0] start);
    logic [PW-1:0] p;
    logic [AW-1:0] a, ii, im, ei, em;
    logic [CW-1:0] cnt;
    p = start;
    for (int n = 0; n < 8; n++) begin
      a = p[AW-1:0];
      if (a == '0) break;
      for (int k = 0; k < 6; k++) q.push_back(mk(0, a - AW'(k), 1'b0, '0, 1'b0, '0, "R2"));
      ii  = mem[8'(a)][AW-1:0];
      im  = mem[8'(a - 1)][AW-1:0];
      cnt = mem[8'(a - 2)][CW-1:0];
      ei  = mem[8'(a - 3)][AW-1:0];
      em  = mem[8'(a - 4)][AW-1:0];
      for (int w = 0; w < int'(cnt); w++) begin
        if (p[AW+1]) q.push_back(mk(0, ii, 1'b0, mem[ii[7:0]], 1'b1, ei, "R4"));
        else         q.push_back(mk(0, ii, 1'b1, 32'hA500_0000 ^ {13'h0, ei}, 1'b0, ei, "R5"));
        ii = ii + im;
        ei = ei + em;
      end
      if (p[AW]) q.push_back(mk(1, '0, 1'b0, '0, 1'b0, '0, "R7"));
      p = mem[8'(a - 5)][PW-1:0];
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      if (mem_req && mem_ack) begin
        if (q.size() == 0) chk(0, "R1", "unexpected access addr", longint'(mem_addr), 0);
        else begin
          e = q.pop_front();
          consumed++;
          chk(e.kind == 0, e.req, "access where pulse expected", 0, 1);
          chk(mem_addr == e.addr, e.req, "address", longint'(mem_addr), longint'(e.addr));
          chk(mem_we == e.we, e.req, "write enable", longint'(mem_we), longint'(e.we));
          if (e.we) begin
            chk(mem_wdata == e.data, "R5", "write data", longint'(mem_wdata), longint'(e.data));
            chk(xfer_ext_addr == e.ext, "R6", "external index", longint'(xfer_ext_addr), longint'(e.ext));
          end
          chk(xfer_out_valid == e.outv, e.req, "out valid", longint'(xfer_out_valid), longint'(e.outv));
          if (e.outv) begin
            chk(xfer_out_data == e.data, "R4", "out data", longint'(xfer_out_data), longint'(e.data));
            chk(xfer_ext_addr == e.ext, "R6", "external index", longint'(xfer_ext_addr), longint'(e.ext));
          end
        end
      end else if (xfer_out_valid) begin
        chk(0, "R4", "out valid without access", 1, 0);
      end
      if (irq) begin
        if (q.size() == 0 || q[0].kind != 1) chk(0, "R7", "unexpected pulse", 1, 0);
        else begin
          e = q.pop_front();
          chk(1, "R7", "pulse", 1, 1);
        end
      end
    end
  end

  task automatic put_tcb(input int top, input logic [PW-1:0] cp, input logic [AW-1:0] em,
                         input logic [AW-1:0] ei, input int cnt, input logic [AW-1:0] im,
                         input logic [AW-1:0] ii);
    mem[top]     = {13'h0, ii};
    mem[top - 1] = {13'h0, im};
    mem[top - 2] = DW'(cnt);
    mem[top - 3] = {13'h0, ei};
    mem[top - 4] = {13'h0, em};
    mem[top - 5] = {11'h0, cp};
  endtask

  task automatic pulse_ptr(input logic [PW-1:0] v);
    @(posedge clk); #1;
    ptr_wr = 1'b1; ptr_wdata = v;
    @(posedge clk); #1;
    ptr_wr = 1'b0;
  endtask

  task automatic run_chain(input logic [PW-1:0] v, input bit inject);
    build_expect(v);
    pulse_ptr(v);
    chk(busy == 1'b1, "R9", "busy after start", longint'(busy), 1);
    for (int c = 0; c < 3000; c++) begin
      if (q.size() == 0 && !busy) break;
      if (inject && c == 9) begin
        chk(busy == 1'b1, "R12", "busy during chain", longint'(busy), 1);
        ptr_wr = 1'b1; ptr_wdata = {2'b11, 19'h15};
      end else ptr_wr = 1'b0;
      @(posedge clk); #1;
    end
    ptr_wr = 1'b0;
    chk(q.size() == 0, "R8", "events left in stream", q.size(), 0);
    chk(busy == 1'b0, "R9", "busy after chain end", longint'(busy), 0);
    q.delete();
  endtask

  task automatic idle_check(input string r);
    repeat (12) @(posedge clk);
    #1;
    chk(busy == 1'b0, r, "stays idle", longint'(busy), 0);
    chk(mem_req == 1'b0, r, "no request", longint'(mem_req), 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_en = 1'b0; ctl_chain = 1'b0; ptr_wr = 1'b0; ptr_wdata = '0;
    stall_mode = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) mem[8'h80 + i] = 32'h1234_0000 + 32'(i * 7);
    // descriptors (address of highest word)
    put_tcb(8'h15, '0, 19'd1, 19'h1000, 4, 19'd1, 19'h0C0);
    put_tcb(8'h1B, {2'b01, 19'h21}, 19'h7FFFF, 19'h2000, 5, 19'd2, 19'h080);
    put_tcb(8'h21, {2'b10, 19'h27}, 19'd4, 19'h3000, 3, 19'h7FFFF, 19'h0D0);
    put_tcb(8'h27, '0, 19'd1, 19'h4000, 0, 19'd1, 19'h0E0);
    put_tcb(8'h2D, '0, 19'd1, 19'h5000, 12, 19'd1, 19'h080);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R9", "reset busy", longint'(busy), 0);
    chk(mem_req == 1'b0, "R1", "reset request", longint'(mem_req), 0);
    chk(irq == 1'b0, "R7", "reset pulse", longint'(irq), 0);
    chk_on = 1;

    // R1: start refused without chain enable, without channel enable, or with zero address
    ctl_en = 1'b1; ctl_chain = 1'b0;
    pulse_ptr({2'b00, 19'h15});
    idle_check("R1");
    ctl_en = 1'b0; ctl_chain = 1'b1;
    pulse_ptr({2'b00, 19'h15});
    ctl_en = 1'b1;
    idle_check("R1");
    pulse_ptr({2'b11, 19'h0});
    idle_check("R1");

    // R5 R6: single inbound descriptor, no pulse (R3 flag clear)
    run_chain({2'b00, 19'h15}, 1'b0);
    for (int i = 0; i < 4; i++)
      chk(mem[8'hC0 + i] == (32'hA500_0000 ^ (32'h1000 + 32'(i))), "R5", "stored word",
          longint'(mem[8'hC0 + i]), longint'(32'hA500_0000 ^ (32'h1000 + 32'(i))));

    // R2 R3 R4 R6 R7 R8 R12: three-link chain with stalls and an ignored pointer write
    stall_mode = 1'b1;
    run_chain({2'b11, 19'h1B}, 1'b1);
    run_chain({2'b11, 19'h1B}, 1'b0);

    // R10: abort in the middle of an outbound descriptor
    build_expect({2'b10, 19'h2D});
    consumed = 0;
    pulse_ptr({2'b10, 19'h2D});
    for (int c = 0; c < 500; c++) begin
      if (consumed >= 10) break;
      @(posedge clk); #1;
    end
    ctl_en = 1'b0;
    q.delete();
    #0;
    chk(mem_req == 1'b0, "R10", "request drops with enable", longint'(mem_req), 0);
    @(posedge clk); #1;
    chk(busy == 1'b0, "R10", "idle after abort", longint'(busy), 0);
    ctl_en = 1'b1;
    idle_check("R10");

    // restart after abort
    stall_mode = 1'b0;
    run_chain({2'b01, 19'h15}, 1'b0);

    chk_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule